// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-node coherence controller for a small shared-memory system. For every memory line it keeps a full presence vector (one bit per processor) and a single dirty flag, together with the line's backing data. Processors send one read or write request at a time over a valid/ready channel. The controller looks up the line and picks an action from the dirty flag. A clean read is served straight from memory. A dirty read or write recalls the line from its single owner. A clean write invalidates every other sharer.

Coherence messages leave on a message channel, one per cycle, and cache responders answer each one with a single-cycle acknowledgement. A recall acknowledgement also carries the line's current data. The requester gets a one-cycle response only after every outstanding acknowledgement has come back. That response carries either read data or a write grant. While a transaction is open, the request channel is closed.

A processor that already holds a line dirty is assumed not to request that same line again. Its cache hits locally. Apart from that, any processor may request any line in any order.

Top module: `dir_home_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every entry is clean with no sharers. Entry e holds data 0xD0000000 + e. `req_ready` is high, and `rsp_valid` and `msg_valid` are low.
- R2: A read from processor i of a clean line sends no message. Its response (`rsp_write`=0, `rsp_proc`=i, memory data) is valid in the cycle after acceptance. The line then gains i as a sharer.
- R3: A read of a dirty line sends one message of kind 1 (recall, keep shared copy) to the owner in the cycle after acceptance. The response carries the data returned with the acknowledgement. Memory takes that data, the line turns clean, and both the owner and i remain sharers.
- R4: A write from processor i to a clean line sends one message of kind 0 (invalidate) to every sharer other than i. These go out on consecutive cycles starting the cycle after acceptance, in ascending processor order.
- R5: The response to a write to a clean line is a grant (`rsp_write`=1) carrying memory data. It appears two cycles after the last acknowledgement is driven, or in the cycle after acceptance when no other sharer exists. Afterwards the line is dirty and held by i alone.
- R6: A write to a dirty line sends one message of kind 2 (recall and invalidate) to the owner. Memory and the response take the data returned with the acknowledgement. The line stays dirty and is held by i alone.
- R7: `req_ready` is low from the cycle after acceptance until after the response. Each accepted request gets exactly one single-cycle response.
- R8: Every message carries the entry index of the request it serves. Kind value 3 never appears.
- R9: A recall is always sent to the last processor granted write access to that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read |
| req_proc | input | 2 | Requesting processor |
| req_idx | input | 4 | Directory entry (line) index |
| msg_valid | output | 1 | Coherence message valid this cycle |
| msg_kind | output | 2 | 0 invalidate, 1 recall to shared, 2 recall and invalidate |
| msg_dest | output | 2 | Destination processor |
| msg_idx | output | 4 | Line index of the message |
| ack_valid | input | 1 | One acknowledgement this cycle |
| ack_data | input | 32 | Line data returned with a recall acknowledgement |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_write | output | 1 | 1 = write grant, 0 = read data |
| rsp_proc | output | 2 | Processor the response is for |
| rsp_data | output | 32 | Line data |

## Verification
A request is accepted on the edge after it is driven. The bench counts cycles from that edge on the falling clock. It expects the k-th message at count k and a response with no messages at count 1. When messages were sent, it expects the response exactly two counts after the last acknowledgement it drove. Acknowledgements come back one to three cycles after their message, in random order, so the counting path is exercised with overlapping traffic. The bench keeps its own directory and cache model to predict each message's destination, kind and order, and each response's data.

// File: rtl/dir_pkg.sv
// Shared encodings for the directory home controller.
// Assumes a two-bit message kind field that cache responders decode.
package dir_pkg;
    typedef enum logic [1:0] {
        MSG_INV        = 2'd0,
        MSG_RECALL_SHR = 2'd1,
        MSG_RECALL_INV = 2'd2
    } msg_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/dir_store.sv
// Directory and backing memory: presence vector, dirty flag and data per line.
// Assumes one combinational read port and one synchronous write port;
// reset clears all directory state and loads a computed data pattern.
module dir_store #(
    parameter int NPROC  = 4,
    parameter int NENTRY = 16,
    parameter int DW     = 32,
    parameter int IW     = $clog2(NENTRY),
    parameter logic [DW-1:0] INIT_BASE = DW'(32'hD000_0000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    output logic [NPROC-1:0] rd_pres,
    output logic             rd_dirty,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [NPROC-1:0] wr_pres,
    input  logic             wr_dirty,
    input  logic             wr_data_en,
    input  logic [DW-1:0]    wr_data
);
    logic [NPROC-1:0] pres_q  [NENTRY];
    logic             dirty_q [NENTRY];
    logic [DW-1:0]    data_q  [NENTRY];

    // Read port: lookup of the addressed line.
    assign rd_pres  = pres_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // Entry storage: reset to clean, then written back at transaction end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NENTRY; e++) begin
                pres_q[e]  <= '0;
                dirty_q[e] <= 1'b0;
                data_q[e]  <= INIT_BASE + DW'(e);
            end
        end else if (wr_en) begin
            pres_q[wr_idx]  <= wr_pres;
            dirty_q[wr_idx] <= wr_dirty;
            if (wr_data_en) begin
                data_q[wr_idx] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dir_fanout.sv
// Message fan-out and acknowledgement counter.
// On load it takes a target mask, then names one target per cycle (lowest
// index first) and counts acknowledgements down from the mask's popcount.
// Assumes load never coincides with an acknowledgement.
module dir_fanout #(
    parameter int NPROC = 4,
    parameter int PW    = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    input  logic             ack,
    output logic             fire,
    output logic [PW-1:0]    dest,
    output logic             last,
    output logic             done
);
    logic [NPROC-1:0] mask_q;
    logic [PW:0]      cnt_q;
    logic [PW:0]      load_cnt;

    // Lowest pending target.
    always_comb begin
        dest = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (mask_q[i]) dest = PW'(i);
        end
    end

    // Number of acknowledgements owed for a new mask.
    always_comb begin
        load_cnt = '0;
        for (int i = 0; i < NPROC; i++) begin
            load_cnt = load_cnt + (PW+1)'(load_mask[i]);
        end
    end

    assign fire = |mask_q;
    assign last = fire && ((mask_q & (mask_q - 1'b1)) == '0);
    assign done = (cnt_q == '0);

    // Pending mask and outstanding acknowledgement count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            mask_q <= load_mask;
            cnt_q  <= load_cnt;
        end else begin
            if (fire) mask_q[dest] <= 1'b0;
            if (ack && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dir_home_ctrl.sv
// Full-map directory home controller (top).
// Serves one read or write request at a time. It picks recall or invalidate
// from the line's dirty flag, waits for all acknowledgements, then responds
// and writes the directory back. Assumes a dirty owner never re-requests its line.
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NENTRY = 16,
    parameter int DW     = 32,
    localparam int PW    = $clog2(NPROC),
    localparam int IW    = $clog2(NENTRY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [PW-1:0] req_proc,
    input  logic [IW-1:0] req_idx,
    output logic          msg_valid,
    output logic [1:0]    msg_kind,
    output logic [PW-1:0] msg_dest,
    output logic [IW-1:0] msg_idx,
    input  logic          ack_valid,
    input  logic [DW-1:0] ack_data,
    output logic          rsp_valid,
    output logic          rsp_write,
    output logic [PW-1:0] rsp_proc,
    output logic [DW-1:0] rsp_data
);
    ctl_state_t       state_q;
    msg_kind_t        kind_q;
    logic             cur_write;
    logic [PW-1:0]    cur_proc;
    logic [IW-1:0]    cur_idx;
    logic [NPROC-1:0] cur_pres;
    logic             cur_dirty;
    logic [DW-1:0]    cur_data;

    logic [NPROC-1:0] rd_pres;
    logic             rd_dirty;
    logic [DW-1:0]    rd_data;
    logic [NPROC-1:0] req_bit;
    logic [NPROC-1:0] cur_bit;
    logic [NPROC-1:0] fan_mask;
    logic             accept;
    logic             f_fire;
    logic [PW-1:0]    f_dest;
    logic             f_last;
    logic             f_done;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign req_bit   = NPROC'(1) << req_proc;
    assign cur_bit   = NPROC'(1) << cur_proc;

    // Targets: owner when dirty, other sharers on a clean write, none otherwise.
    always_comb begin
        if (rd_dirty)       fan_mask = rd_pres;
        else if (req_write) fan_mask = rd_pres & ~req_bit;
        else                fan_mask = '0;
    end

    dir_store #(.NPROC(NPROC), .NENTRY(NENTRY), .DW(DW), .IW(IW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (req_idx),
        .rd_pres    (rd_pres),
        .rd_dirty   (rd_dirty),
        .rd_data    (rd_data),
        .wr_en      (state_q == ST_RESP),
        .wr_idx     (cur_idx),
        .wr_pres    (cur_write ? cur_bit : (cur_pres | cur_bit)),
        .wr_dirty   (cur_write),
        .wr_data_en (cur_dirty),
        .wr_data    (cur_data)
    );

    dir_fanout #(.NPROC(NPROC), .PW(PW)) u_fanout (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_mask (fan_mask),
        .ack       (ack_valid),
        .fire      (f_fire),
        .dest      (f_dest),
        .last      (f_last),
        .done      (f_done)
    );

    // Transaction sequencing: idle, send messages, await acks, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) state_q <= (fan_mask == '0) ? ST_RESP : ST_SEND;
                ST_SEND: if (f_last) state_q <= ST_WAIT;
                ST_WAIT: if (f_done) state_q <= ST_RESP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Transaction context: latched request and entry, recalled data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= MSG_INV;
            cur_write <= 1'b0;
            cur_proc  <= '0;
            cur_idx   <= '0;
            cur_pres  <= '0;
            cur_dirty <= 1'b0;
            cur_data  <= '0;
        end else if (accept) begin
            cur_write <= req_write;
            cur_proc  <= req_proc;
            cur_idx   <= req_idx;
            cur_pres  <= rd_pres;
            cur_dirty <= rd_dirty;
            cur_data  <= rd_data;
            if (!rd_dirty)      kind_q <= MSG_INV;
            else if (req_write) kind_q <= MSG_RECALL_INV;
            else                kind_q <= MSG_RECALL_SHR;
        end else if (ack_valid && cur_dirty && state_q != ST_IDLE) begin
            cur_data <= ack_data;
        end
    end

    assign msg_valid = (state_q == ST_SEND) && f_fire;
    assign msg_kind  = kind_q;
    assign msg_dest  = f_dest;
    assign msg_idx   = cur_idx;

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_write = cur_write;
    assign rsp_proc  = cur_proc;
    assign rsp_data  = cur_data;
endmodule

// File: rtl/dir_home_ctrl_chk.sv
// Protocol checker for dir_home_ctrl, attached by bind.
// Tracks messages minus acknowledgements to check response ordering.
module dir_home_ctrl_chk #(
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          msg_valid,
    input logic [1:0]    msg_kind,
    input logic [PW-1:0] msg_dest,
    input logic          ack_valid,
    input logic          rsp_valid,
    input logic [PW-1:0] cur_proc
);
    logic [7:0] outstanding_q;

    // Messages sent but not yet acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding_q <= '0;
        else        outstanding_q <= outstanding_q + 8'(msg_valid) - 8'(ack_valid);
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !msg_valid));

    // R7
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R5
    grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (outstanding_q == 8'd0));

    // R4
    inv_skips_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd0) |-> (msg_dest != cur_proc));

    // R8
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_kind != 2'd3));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .msg_valid (msg_valid),
    .msg_kind  (msg_kind),
    .msg_dest  (msg_dest),
    .ack_valid (ack_valid),
    .rsp_valid (rsp_valid),
    .cur_proc  (cur_proc)
);

// File: tb/dir_home_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, with a
// directory/cache model predicting messages, timing and response data.
module dir_home_ctrl_bench;
    localparam int NP = 4;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_proc = '0;
    logic [3:0]  req_idx = '0;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_dest;
    logic [3:0]  msg_idx;
    logic        ack_valid = 1'b0;
    logic [31:0] ack_data = '0;
    logic        rsp_valid;
    logic        rsp_write;
    logic [1:0]  rsp_proc;
    logic [31:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [3:0]  m_pres  [NE];
    logic        m_dirty [NE];
    logic [31:0] m_mem   [NE];
    logic [31:0] c_val   [NE];
    logic [31:0] last_rsp_data;

    always #2.5 clk = ~clk;

    dir_home_ctrl u_dir_home_ctrl (.*);

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input int p, input int idx);
        int exp_dest [4];
        int exp_n = 0;
        int exp_kind = 0;
        int owner = 0;
        logic [31:0] exp_data;
        string rtag;
        string ttag;
        int seen_dest [4];
        int seen_kind [4];
        int seen_idx  [4];
        int seen_cyc  [4];
        int due [4];
        bit acked [4];
        int n_seen = 0;
        int last_ack = 0;
        int rsp_cyc = -1;
        bit bad_ready = 0;
        logic        g_write = 1'b0;
        logic [1:0]  g_proc = '0;
        logic [31:0] g_data = '0;
        int cyc;

        // Expected behaviour from the model.
        if (m_dirty[idx]) begin
            for (int k = 0; k < NP; k++) if (m_pres[idx][k]) owner = k;
            exp_n = 1;
            exp_dest[0] = owner;
            exp_kind = wr ? 2 : 1;
            exp_data = c_val[idx];
            rtag = wr ? "R6" : "R3";
        end else if (wr) begin
            for (int k = 0; k < NP; k++) begin
                if (m_pres[idx][k] && k != p) begin
                    exp_dest[exp_n] = k;
                    exp_n++;
                end
            end
            exp_kind = 0;
            exp_data = m_mem[idx];
            rtag = "R4";
        end else begin
            exp_data = m_mem[idx];
            rtag = "R2";
        end
        ttag = (wr && !m_dirty[idx]) ? "R5" : rtag;

        req_valid = 1'b1;
        req_write = wr;
        req_proc  = 2'(p);
        req_idx   = 4'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (cyc < 60) begin
            if (msg_valid && n_seen < 4) begin
                seen_dest[n_seen] = int'(msg_dest);
                seen_kind[n_seen] = int'(msg_kind);
                seen_idx[n_seen]  = int'(msg_idx);
                seen_cyc[n_seen]  = cyc;
                due[n_seen]       = cyc + 1 + int'($urandom % 3);
                acked[n_seen]     = 0;
                n_seen++;
            end
            if (req_ready && !rsp_valid) bad_ready = 1;
            if (rsp_valid) begin
                rsp_cyc = cyc;
                g_write = rsp_write;
                g_proc  = rsp_proc;
                g_data  = rsp_data;
                break;
            end
            ack_valid = 1'b0;
            for (int k = 0; k < n_seen; k++) begin
                if (!ack_valid && !acked[k] && due[k] <= cyc) begin
                    acked[k]  = 1;
                    ack_valid = 1'b1;
                    ack_data  = c_val[idx];
                    last_ack  = cyc;
                end
            end
            @(negedge clk);
            cyc++;
        end
        ack_valid = 1'b0;

        chk(n_seen == exp_n, rtag, "message count", 32'(n_seen), 32'(exp_n));
        for (int k = 0; k < n_seen && k < exp_n; k++) begin
            chk(seen_dest[k] == exp_dest[k], m_dirty[idx] ? "R9" : rtag,
                "message destination", 32'(seen_dest[k]), 32'(exp_dest[k]));
            chk(seen_kind[k] == exp_kind, rtag, "message kind",
                32'(seen_kind[k]), 32'(exp_kind));
            chk(seen_cyc[k] == k + 1, rtag, "message cycle",
                32'(seen_cyc[k]), 32'(k + 1));
            chk(seen_idx[k] == idx, "R8", "message index", 32'(seen_idx[k]), 32'(idx));
        end
        chk(rsp_cyc == ((exp_n == 0) ? 1 : last_ack + 2), ttag, "response cycle",
            32'(rsp_cyc), 32'((exp_n == 0) ? 1 : last_ack + 2));
        chk(g_data == exp_data, rtag, "response data", g_data, exp_data);
        chk(g_write == wr && int'(g_proc) == p, "R7", "response write/proc",
            {30'd0, g_write, 1'b0} | 32'(g_proc), {30'd0, wr, 1'b0} | 32'(p));
        chk(!bad_ready, "R7", "ready during transaction", 32'(bad_ready), 32'd0);
        last_rsp_data = g_data;

        // Model update.
        if (wr) begin
            if (m_dirty[idx]) m_mem[idx] = c_val[idx];
            m_pres[idx]  = 4'(1 << p);
            m_dirty[idx] = 1'b1;
            c_val[idx]   = $urandom;
        end else begin
            if (m_dirty[idx]) m_mem[idx] = c_val[idx];
            m_pres[idx]  = m_pres[idx] | 4'(1 << p);
            m_dirty[idx] = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int e = 0; e < NE; e++) begin
            m_pres[e]  = '0;
            m_dirty[e] = 1'b0;
            m_mem[e]   = 32'hD000_0000 + 32'(e);
            c_val[e]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !msg_valid, "R1", "idle after reset",
            {29'd0, req_ready, rsp_valid, msg_valid}, 32'h4);

        run_req(0, 0, 3);
        chk(last_rsp_data == 32'hD000_0003, "R1", "initial line data",
            last_rsp_data, 32'hD000_0003);
        run_req(0, 1, 3);
        run_req(0, 2, 3);
        run_req(1, 1, 3);   // invalidate 0 and 2, requester skipped
        run_req(0, 3, 3);   // recall to shared from 1
        run_req(1, 0, 3);   // invalidate 1 and 3
        run_req(1, 2, 3);   // recall-invalidate from 0
        run_req(1, 2, 5);   // clean write, no sharers
        run_req(1, 0, 5);   // recall-invalidate from 2
        run_req(0, 3, 5);   // recall to shared from 0

        for (int t = 0; t < 400; t++) begin
            int idx = int'($urandom % NE);
            int p   = int'($urandom % NP);
            bit wr  = 1'($urandom % 2);
            if (m_dirty[idx] && m_pres[idx][p]) p = (p + 1) % NP;
            run_req(wr, p, idx);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule